// File: doc/BRIEF.md
# Parking Round-Robin Bus Arbiter

This block is the central arbiter of a shared parallel bus with several masters. Each master has its own request line and its own grant line. The arbiter hands the bus to one master at a time. It rotates through the masters so that none is locked out. When nobody else wants the bus, the grant stays with the master that held it last. That master can then begin another transaction at once, without waiting for arbitration.

The next owner is picked while the current transfer is still running. The picker is combinational and watches the request lines on every clock. The grant moves only on a clock where the bus is sampled idle, meaning both the frame and initiator-ready strobes are inactive. The old grant is dropped on that edge. The chosen master receives its grant one clock later, so there is always a clock with no grant in between. During that gap the choice is already fixed. It holds even if the chosen master withdraws its request.

Top module: `bus_park_arbiter`

## Requirements
- R1: While reset is asserted and on the first clock after it, the grant vector equals 1 (bit 0 set), meaning the bus is parked on master 0.
- R2: At most one bit of the grant vector is 1 at any time.
- R3: When no master other than the current grant holder requests, the grant vector keeps its value, whatever the bus-idle input is.
- R4: A nonzero grant becomes zero only after a clock edge at which bus_idle was 1 and some other master was requesting.
- R5: While bus_idle is 0, a nonzero grant never changes, even if other masters request.
- R6: A gap with an all-zero grant lasts exactly one clock. After it, exactly one grant bit is set.
- R7: The master granted after a gap is the first requester found by scanning upward from the previous owner's index plus one, wrapping from N-1 to 0. The scan uses the requests sampled at the edge where the old grant was dropped.
- R8: When all masters request and the bus is idle on every clock, each master is granted within 2N clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N | Request line per master, active high |
| bus_idle | input | 1 | High when the frame and initiator-ready strobes are both inactive |
| gnt | output | N | Grant line per master, at most one high |

## Verification
The properties take bus_idle to be a plain level sampled on each rising edge. They need no relation between bus_idle and the grant holder's activity, and request lines may change freely on any clock. The stimulus drives req and bus_idle only on falling edges. Random patterns mix sparse and dense request vectors with busy and idle spans. Directed sequences cover the cases the random mix may miss:
- the reset park on master 0;
- an owner that requests alone;
- a long busy span with others waiting;
- wrap-around from the highest index;
- a chosen master that withdraws its request during the gap;
- all masters requesting at once.

// File: rtl/bus_park_arbiter.sv
module bus_park_arbiter #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         bus_idle,
  output logic [N-1:0] gnt
);

  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [W-1:0] owner_q, next_q, pick;
  logic         gap_q;
  logic         others;

  assign others = |(req & ~(ONE << owner_q));

  always_comb begin
    pick = owner_q;
    for (int k = N - 1; k >= 1; k--) begin
      if (req[(int'(owner_q) + k) % N])
        pick = W'((int'(owner_q) + k) % N);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= '0;
      next_q  <= '0;
      gap_q   <= 1'b0;
      gnt     <= ONE;
    end else if (gap_q) begin
      gnt     <= ONE << next_q;
      owner_q <= next_q;
      gap_q   <= 1'b0;
    end else if (others && bus_idle) begin
      gnt     <= '0;
      next_q  <= pick;
      gap_q   <= 1'b1;
    end
  end

endmodule

module bus_park_arbiter_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req,
  input logic         bus_idle,
  input logic [N-1:0] gnt
);

  a_r2_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r3_parked_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(|gnt) && (($past(req) & ~$past(gnt)) == '0)) |-> (gnt == $past(gnt)));

  a_r4_drop_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt == '0) && $past(|gnt)) |-> ($past(bus_idle) && (($past(req) & ~$past(gnt)) != '0)));

  a_r5_busy_no_switch: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(|gnt) && !$past(bus_idle)) |-> (gnt == $past(gnt)));

  a_r6_gap_single: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gnt) == '0) |-> ($countones(gnt) == 1));

endmodule

bind bus_park_arbiter bus_park_arbiter_chk #(.N(N)) u_chk (.*);

// File: tb/tb_bus_park_arbiter.sv
module tb_bus_park_arbiter;
  localparam int N = 4;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic bus_idle = 1'b0;
  logic [N-1:0] gnt;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [N-1:0] exp_gnt;
  int owner;
  int pend;
  bit gap;

  always #(PERIOD/2) clk = ~clk;

  bus_park_arbiter #(.N(N)) dut (.clk(clk), .rst_n(rst_n), .req(req), .bus_idle(bus_idle), .gnt(gnt));

  function automatic int rr_pick(int from, logic [N-1:0] r);
    for (int k = 1; k <= N; k++)
      if (r[(from + k) % N]) return (from + k) % N;
    return from;
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: gnt actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic [N-1:0] r, logic idle);
    string tag;
    req = r;
    bus_idle = idle;
    if (gap) begin
      exp_gnt = N'(1) << pend;
      owner = pend;
      gap = 1'b0;
      tag = "R6/R7";
    end else if (((r & ~(N'(1) << owner)) != '0) && idle) begin
      pend = rr_pick(owner, r);
      gap = 1'b1;
      exp_gnt = '0;
      tag = "R4";
    end else if ((r & ~(N'(1) << owner)) != '0) begin
      tag = "R5";
    end else begin
      tag = "R3";
    end
    @(negedge clk);
    check(tag, gnt, exp_gnt);
    checks++;
    if (!$onehot0(gnt)) begin
      fails++;
      $display("FAIL R2: gnt actual %b expected at most one bit", gnt);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] seen;
    void'($urandom(32'd2024));
    exp_gnt = 1;
    owner = 0;
    pend = 0;
    gap = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", gnt, 4'b0001);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", gnt, 4'b0001);

    repeat (4) step(4'b0000, 1'b1);
    repeat (4) step(4'b0001, 1'b1);
    repeat (6) step(4'b0110, 1'b0);
    step(4'b0110, 1'b1);
    step(4'b0000, 1'b0);
    repeat (3) step(4'b1000, 1'b1);
    repeat (2) step(4'b1000, 1'b0);
    step(4'b0101, 1'b1);
    step(4'b0000, 1'b1);
    repeat (3) step(4'b0000, 1'b1);
    step(4'b0001, 1'b1);
    step(4'b0000, 1'b1);

    seen = '0;
    for (int i = 0; i < 2 * N; i++) begin
      step(4'b1111, 1'b1);
      seen |= gnt;
    end
    checks++;
    if (seen !== 4'b1111) begin
      fails++;
      $display("FAIL R8: granted set actual %b expected %b", seen, 4'b1111);
    end

    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] r;
      r = (i % 3 == 0) ? N'($urandom) : (N'($urandom) & N'($urandom));
      step(r, 1'($urandom % 3 != 0));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule